// File: doc/BRIEF.md
# Asynchronous Bus Strobe Edge Synchronizer

This block sits between a slow host bus and the fast internal clock domain of a peripheral. It receives the host's active-low read and write strobes with no timing relation to the internal clock. It passes each one through a register chain and gives back two things per strobe: the synchronized level of the strobe, and a done pulse one clock wide when the access ends. Downstream register logic uses the write done pulse to commit a write and the read done pulse to advance a read pointer.

The done pulse is built only from registered samples. It is never formed by combining a sampled value with the raw input, so its width never depends on where the asynchronous edge falls inside a clock period. In return the host must hold each strobe for a minimum number of clocks and leave a minimum gap between accesses. The block flags any strobe that is too short and any strobe that starts too soon after the one before it.

When read and write are asserted together, write takes precedence: the write completes normally, the overlapping read is dropped, and a conflict flag is raised for as long as the overlap lasts.

Top module: `strobe_edge_sync`

## Requirements
- R1: Each raw strobe passes through a two-stage register chain that resets high. `rd_active` / `wr_active` are high exactly while the second stage holds 0. They go high in the cycle after the second rising edge that samples the raw strobe low.
- R2: Every accepted access produces exactly one done pulse, and the pulse is one clock wide.
- R3: A done pulse appears only in the first cycle after the active level drops, when the second stage has returned to 1 and the stage behind it still holds 0. A raw strobe change that begins and ends between two rising edges has no effect.
- R4: An access whose active level lasts fewer than MIN_ASSERT cycles (default 2) produces no done pulse. Instead, `short_err` is high in the cycle where the done pulse would have appeared.
- R5: If an active level begins after fewer than MIN_GAP cycles (default 2) of inactivity on the same strobe, `gap_err` is high in the first active cycle. The access itself is still handled normally.
- R6: While `rst_n` is low, and after its release while both raw strobes stay high, all outputs are 0.
- R7: `conflict` is high in every cycle in which `rd_active` and `wr_active` are both high.
- R8: A read whose active level overlapped the write active level in any cycle gives no `rd_done`. The write is unaffected.
- R9: Read and write are handled independently: a read that does not overlap a write gives only `rd_done`, and a write gives only `wr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n_async | input | 1 | Raw read strobe, active low, asynchronous |
| wr_n_async | input | 1 | Raw write strobe, active low, asynchronous |
| rd_active | output | 1 | Synchronized read strobe, active high |
| wr_active | output | 1 | Synchronized write strobe, active high |
| rd_done | output | 1 | One-cycle pulse at the end of an accepted read |
| wr_done | output | 1 | One-cycle pulse at the end of an accepted write |
| short_err | output | 1 | One-cycle flag: a strobe ended before the minimum hold time |
| gap_err | output | 1 | One-cycle flag: a strobe began before the minimum gap elapsed |
| conflict | output | 1 | High while both synchronized strobes are active |

## Verification
The read trailing edge and the write trailing edge can land in the same cycle. The same overlap also decides whether a read survives. This is provoked by overlapping accesses in both directed form (a read nested inside a write) and random form (independent lengths and offsets on the two strobes). In each cycle the result is judged against a bench model: `wr_done` must still fire, `rd_done` must stay low, and `conflict` must cover exactly the shared active cycles.

// File: rtl/strobe_sync_pkg.sv
`timescale 1ns/1ps
package strobe_sync_pkg;
  // Per-strobe view taken from the register chain
  typedef struct packed {
    logic level;  // strobe active (second stage low)
    logic lead;   // first active cycle
    logic trail;  // first inactive cycle after an active run
  } strobe_view_t;

  localparam int CH_RD  = 0;
  localparam int CH_WR  = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/strobe_sync_chain.sv
`timescale 1ns/1ps
module strobe_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         raw_n,
  output strobe_sync_pkg::strobe_view_t view
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;                       // deasserted level
    else        sh <= {sh[STAGES-1:0], raw_n};
  end

  assign view.level = ~sh[STAGES-1];
  assign view.lead  = ~sh[STAGES-1] &  sh[STAGES];
  assign view.trail =  sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/strobe_timing_check.sv
`timescale 1ns/1ps
module strobe_timing_check #(
  parameter int MIN_ASSERT = 2,
  parameter int MIN_GAP    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobe_sync_pkg::strobe_view_t view,
  output logic                          ok_trail,
  output logic                          short_flag,
  output logic                          gap_flag
);
  localparam int AW = $clog2(MIN_ASSERT + 1);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [AW-1:0] A_SAT = AW'(MIN_ASSERT);
  localparam logic [GW-1:0] G_SAT = GW'(MIN_GAP);

  logic [AW-1:0] hold_cnt;  // active cycles so far, saturating
  logic [GW-1:0] idle_cnt;  // inactive cycles so far, saturating

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      idle_cnt <= G_SAT;   // first access after reset never flags a gap
    end else if (view.level) begin
      idle_cnt <= '0;
      if (hold_cnt != A_SAT) hold_cnt <= hold_cnt + 1'b1;
    end else begin
      hold_cnt <= '0;
      if (idle_cnt != G_SAT) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign ok_trail   = view.trail & (hold_cnt == A_SAT);
  assign short_flag = view.trail & (hold_cnt != A_SAT);
  assign gap_flag   = view.lead  & (idle_cnt != G_SAT);
endmodule

// File: rtl/strobe_arbiter.sv
`timescale 1ns/1ps
module strobe_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_level,
  input  logic wr_level,
  input  logic rd_ok,
  input  logic wr_ok,
  output logic rd_done,
  output logic wr_done,
  output logic conflict
);
  logic rd_spoiled;  // current read overlapped a write

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rd_spoiled <= 1'b0;
    else if (rd_level & wr_level) rd_spoiled <= 1'b1;
    else if (!rd_level)           rd_spoiled <= 1'b0;
  end

  assign wr_done  = wr_ok;
  assign rd_done  = rd_ok & ~rd_spoiled;
  assign conflict = rd_level & wr_level;
endmodule

// File: rtl/strobe_edge_sync.sv
`timescale 1ns/1ps
module strobe_edge_sync #(
  parameter int STAGES     = 2,
  parameter int MIN_ASSERT = 2,
  parameter int MIN_GAP    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n_async,
  input  logic wr_n_async,
  output logic rd_active,
  output logic wr_active,
  output logic rd_done,
  output logic wr_done,
  output logic short_err,
  output logic gap_err,
  output logic conflict
);
  import strobe_sync_pkg::*;

  logic [NUM_CH-1:0] raw_n;
  strobe_view_t      view [NUM_CH];
  logic [NUM_CH-1:0] ok_v, short_v, gap_v;

  assign raw_n[CH_RD] = rd_n_async;
  assign raw_n[CH_WR] = wr_n_async;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    strobe_sync_chain #(.STAGES(STAGES)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_n (raw_n[c]),
      .view  (view[c])
    );
    strobe_timing_check #(.MIN_ASSERT(MIN_ASSERT), .MIN_GAP(MIN_GAP)) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .view       (view[c]),
      .ok_trail   (ok_v[c]),
      .short_flag (short_v[c]),
      .gap_flag   (gap_v[c])
    );
  end

  strobe_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_level (view[CH_RD].level),
    .wr_level (view[CH_WR].level),
    .rd_ok    (ok_v[CH_RD]),
    .wr_ok    (ok_v[CH_WR]),
    .rd_done  (rd_done),
    .wr_done  (wr_done),
    .conflict (conflict)
  );

  assign rd_active = view[CH_RD].level;
  assign wr_active = view[CH_WR].level;
  assign short_err = |short_v;
  assign gap_err   = |gap_v;
endmodule

// File: rtl/strobe_edge_sync_checker.sv
`timescale 1ns/1ps
module strobe_edge_sync_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_active,
  input logic wr_active,
  input logic rd_done,
  input logic wr_done,
  input logic short_err,
  input logic gap_err
);
  assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  assert_rd_trailing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (!rd_active && $past(rd_active)));
  assert_wr_trailing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!wr_active && $past(wr_active)));
  assert_gap_on_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> ((rd_active && !$past(rd_active)) || (wr_active && !$past(wr_active))));
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !$past(wr_active));
  assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_done && !wr_done && !short_err && !gap_err));
endmodule

bind strobe_edge_sync strobe_edge_sync_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_active (rd_active),
  .wr_active (wr_active),
  .rd_done   (rd_done),
  .wr_done   (wr_done),
  .short_err (short_err),
  .gap_err   (gap_err)
);

// File: tb/tb_strobe_edge_sync.sv
`timescale 1ns/1ps
module tb_strobe_edge_sync;
  localparam int MIN_A = 2;
  localparam int MIN_G = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic rd_active, wr_active, rd_done, wr_done, short_err, gap_err, conflict;

  int checks = 0, errors = 0;
  int n_rd_done, n_wr_done, n_short, n_gap, n_conf, n_rd_act;

  always #2 clk = ~clk;  // 250 MHz

  strobe_edge_sync dut (
    .clk(clk), .rst_n(rst_n), .rd_n_async(rd_n), .wr_n_async(wr_n),
    .rd_active(rd_active), .wr_active(wr_active), .rd_done(rd_done),
    .wr_done(wr_done), .short_err(short_err), .gap_err(gap_err),
    .conflict(conflict)
  );

  // Bench model state: sampled strobe history and counters per channel
  logic [2:0] msh [2];
  int hc [2];
  int gc [2];
  bit spoiled;

  function automatic bit raw_of(input int ch);
    return (ch == 0) ? rd_n : wr_n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin msh[c] = 3'b111; hc[c] = 0; gc[c] = MIN_G; end
      spoiled = 0;
    end else begin
      if (!msh[0][1] && !msh[1][1]) spoiled = 1;
      else if (msh[0][1])           spoiled = 0;
      for (int c = 0; c < 2; c++) begin
        if (!msh[c][1]) begin hc[c] = (hc[c] < MIN_A) ? hc[c] + 1 : hc[c]; gc[c] = 0; end
        else            begin gc[c] = (gc[c] < MIN_G) ? gc[c] + 1 : gc[c]; hc[c] = 0; end
        msh[c] = {msh[c][1:0], raw_of(c)};
      end
    end
  end

  function automatic bit e_lvl(input int c);   return !msh[c][1]; endfunction
  function automatic bit e_trail(input int c); return msh[c][1] && !msh[c][2]; endfunction
  function automatic bit e_lead(input int c);  return !msh[c][1] && msh[c][2]; endfunction

  task automatic chk(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_n(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(posedge clk) begin
    #1;
    chk(rd_active, e_lvl(0), "R1 rd_active");
    chk(wr_active, e_lvl(1), "R1 wr_active");
    chk(rd_done, e_trail(0) && hc[0] >= MIN_A && !spoiled, "R3 rd_done");
    chk(wr_done, e_trail(1) && hc[1] >= MIN_A, "R3 wr_done");
    chk(short_err, (e_trail(0) && hc[0] < MIN_A) || (e_trail(1) && hc[1] < MIN_A), "R4 short_err");
    chk(gap_err, (e_lead(0) && gc[0] < MIN_G) || (e_lead(1) && gc[1] < MIN_G), "R5 gap_err");
    chk(conflict, e_lvl(0) && e_lvl(1), "R7 conflict");
    if (!rst_n) chk(rd_done | wr_done | rd_active | wr_active | conflict, 1'b0, "R6 in reset");
    n_rd_done += rd_done; n_wr_done += wr_done; n_short += short_err;
    n_gap += gap_err; n_conf += conflict; n_rd_act += rd_active;
  end

  task automatic clear_counts();
    n_rd_done = 0; n_wr_done = 0; n_short = 0; n_gap = 0; n_conf = 0; n_rd_act = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int ch, input int len, input int pre);
    repeat (pre) @(negedge clk);
    if (ch == 0) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (len) @(negedge clk);
    if (ch == 0) rd_n = 1'b1; else wr_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_counts();
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R6: quiet after release with idle strobes
    chk_n(n_rd_done + n_wr_done + n_short + n_gap + n_conf, 0, "R6 quiet after reset");

    // R2 / R9: single read of three cycles
    clear_counts(); strobe(0, 3, 0); idle(8);
    chk_n(n_rd_done, 1, "R2 one rd_done per read");
    chk_n(n_wr_done, 0, "R9 no wr_done for read");
    // R9: single write
    clear_counts(); strobe(1, 4, 0); idle(8);
    chk_n(n_wr_done, 1, "R9 one wr_done per write");
    chk_n(n_rd_done, 0, "R9 no rd_done for write");
    // R4: one-cycle strobe is too short
    clear_counts(); strobe(0, 1, 0); idle(8);
    chk_n(n_rd_done, 0, "R4 short read not accepted");
    chk_n(n_short, 1, "R4 short flag");
    // R5: back-to-back reads with one idle cycle
    clear_counts(); strobe(0, 3, 0); strobe(0, 3, 1); idle(8);
    chk_n(n_rd_done, 2, "R5 both reads accepted");
    chk_n(n_gap, 1, "R5 gap flag");
    // R3: glitch between rising edges is never sampled
    clear_counts();
    @(negedge clk); #0.5 rd_n = 1'b0; #1 rd_n = 1'b1;
    idle(6);
    chk_n(n_rd_act, 0, "R3 glitch not seen");
    chk_n(n_rd_done, 0, "R3 glitch no pulse");
    // R8 / R7: read nested inside a write
    clear_counts();
    fork strobe(1, 5, 0); strobe(0, 3, 1); join
    idle(8);
    chk_n(n_wr_done, 1, "R8 write completes");
    chk_n(n_rd_done, 0, "R8 read dropped");
    chk_n(n_conf, 3, "R7 conflict cycles");

    // Random traffic, checked cycle by cycle against the model
    for (int i = 0; i < 400; i++) begin
      int mode = $urandom_range(0, 2);
      int la = $urandom_range(1, 6);
      int lb = $urandom_range(1, 6);
      int off = $urandom_range(0, 4);
      if (mode == 0)      strobe(0, la, 0);
      else if (mode == 1) strobe(1, la, 0);
      else fork strobe(1, la, 0); strobe(0, lb, off); join
      idle($urandom_range(1, 5));
    end

    // R6: reset with a read held low gives no pulse
    rd_n = 1'b0; idle(3);
    rst_n = 1'b0; rd_n = 1'b1; idle(3);
    rst_n = 1'b1; clear_counts(); idle(6);
    chk_n(n_rd_done + n_short + n_gap, 0, "R6 no pulse after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule